// File: doc/BRIEF.md
# Strobe-Toggled Clock Divider

This block derives a slow, square clock from a fast system clock without ever using a derived signal as a clock. A modulo counter, clocked by the system clock, raises a registered strobe for exactly one cycle every `RATIO` cycles. With the default ratio of 100 this is a 1% duty pulse.

A two-state machine in the same clock domain watches the strobe. On each cycle in which the strobe is high it moves to the other state, and its output follows the state. The result is a 50% duty clock with a period of `2*RATIO` input cycles. With a 100 MHz input and the default ratio, that is 500 kHz.

The states are `PH_LOW` (output 0) and `PH_HIGH` (output 1). There are two transitions:

- `PH_LOW -> PH_HIGH` on a strobe.
- `PH_HIGH -> PH_LOW` on a strobe.

Without a strobe, each state holds. Both outputs are meant to be used as enables or observed signals, not as clocks for other logic.

Top module: `strb_clk_div`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, both `strobe_o` and `clk_o` are 0 after that edge.
- R2: After reset is released, `strobe_o` first goes high following the `RATIO`-th rising edge.
- R3: `strobe_o` is high for exactly one clock cycle each time it is asserted.
- R4: Successive strobe pulses begin exactly `RATIO` clock cycles apart, which is a duty of 1/`RATIO`.
- R5: On the rising edge after a cycle in which `strobe_o` is high, `clk_o` inverts. The move is `PH_LOW -> PH_HIGH` or `PH_HIGH -> PH_LOW`.
- R6: On a rising edge after a cycle in which `strobe_o` is low, `clk_o` keeps its value.
- R7: `clk_o` spends exactly `RATIO` cycles high and `RATIO` cycles low, so its period is `2*RATIO` cycles at 50% duty. After reset it first rises following edge `RATIO+1`.
- R8: Asserting reset in the middle of a run returns both outputs to 0 and restarts the sequence from the beginning.
- R9: The behaviour in R2 to R7 holds for a non-default `RATIO` (checked with 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_o | output | 1 | One-cycle pulse every `RATIO` cycles |
| clk_o | output | 1 | 50% duty toggled clock, period `2*RATIO` |

## Verification
The bench targets three corner cases.

- **Strobe placement right after reset release.** A counter compared one value too early or too late would shift the first pulse off edge `RATIO` and make the spacing `RATIO±1`.
- **One-cycle delay between strobe and toggle.** A toggle taken straight from the counter's terminal value, or one that misses the registered strobe, shows up as a first rising edge on the wrong cycle or as an uneven high/low split.
- **Mid-run reset.** A design that left the phase state or the counter uncleared would restart with an inverted `clk_o` or an early strobe.

A second instance with a ratio of 7 catches widths or terminal values hard-wired to the default.

// File: rtl/strb_clk_div_pkg.sv
package strb_clk_div_pkg;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

endpackage

// File: rtl/strb_counter.sv
module strb_counter #(
    parameter int RATIO = 100
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] TERM = CW'(RATIO - 1);

    logic [CW-1:0] count_q;
    logic          at_term;

    // terminal decode; registered below so the strobe is glitch free
    always_comb begin
        at_term = (count_q == TERM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            strobe  <= 1'b0;
        end else begin
            count_q <= at_term ? '0 : count_q + 1'b1;
            strobe  <= at_term;
        end
    end

endmodule

// File: rtl/strb_phase_fsm.sv
module strb_phase_fsm
    import strb_clk_div_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic clk_out
);
    phase_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (strobe) state_d = PH_HIGH;
            PH_HIGH: if (strobe) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_LOW;
        else     state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PH_LOW:  clk_out = 1'b0;
            PH_HIGH: clk_out = 1'b1;
            default: clk_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/strb_clk_div.sv
module strb_clk_div #(
    parameter int RATIO = 100
) (
    input  logic clk,
    input  logic rst,
    output logic strobe_o,
    output logic clk_o
);
    logic strobe_w;

    strb_counter #(.RATIO(RATIO)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe_w)
    );

    strb_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe_w),
        .clk_out (clk_o)
    );

    assign strobe_o = strobe_w;

endmodule

// File: rtl/strb_clk_div_chk.sv
module strb_clk_div_chk #(
    parameter int RATIO = 100
) (
    input logic clk,
    input logic rst,
    input logic strobe_o,
    input logic clk_o
);
    localparam int GW = $clog2(RATIO + 2);

    // cycles since reset or since the last strobe
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                gap_q <= '0;
        else if (strobe_o)      gap_q <= GW'(1);
        else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!strobe_o && !clk_o));

    // R3
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

    // R4
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (gap_q == GW'(RATIO)));

    // R5
    toggle_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> (clk_o != $past(clk_o)));

    // R6
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe_o |=> $stable(clk_o));

endmodule

bind strb_clk_div strb_clk_div_chk #(.RATIO(RATIO)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .strobe_o (strobe_o),
    .clk_o    (clk_o)
);

// File: tb/strb_clk_div_tb.sv
module strb_clk_div_tb;
    localparam int RA = 100;
    localparam int RB = 7;

    typedef struct {
        int unsigned cyc;
        bit          stb;
        bit          ck;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb_a, ck_a, stb_b, ck_b;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    int rst_cycles = 0;
    int last_stb  = -1;
    int last_edge = -1;
    bit prev_ck   = 1'b0;
    bit done      = 1'b0;

    always #5 clk = ~clk;

    strb_clk_div #(.RATIO(RA)) u_dut (
        .clk(clk), .rst(rst), .strobe_o(stb_a), .clk_o(ck_a));
    strb_clk_div #(.RATIO(RB)) u_dut_b (
        .clk(clk), .rst(rst), .strobe_o(stb_b), .clk_o(ck_b));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_stb(int unsigned c, int r);
        return (c > 0) && (c % r == 0);
    endfunction

    function automatic bit model_ck(int unsigned c, int r);
        return (c >= 1) ? bit'(((c - 1) / r) % 2) : 1'b0;
    endfunction

    // driver: queue the expected results, then run n cycles out of reset
    task automatic run_phase(input int n);
        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        q.delete();
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.cyc = i;
            e.stb = model_stb(i, RA);
            e.ck  = model_ck(i, RA);
            q.push_back(e);
        end
        rst = 1'b0;
        repeat (n) @(posedge clk);
        #1 rst = 1'b1;
        @(negedge clk);
        check(q.size() == 0, "R8 queue drained", q.size(), 0);
    endtask

    // monitor: compare on falling edges
    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                if (rst_cycles >= 1) begin
                    check(stb_a == 1'b0, "R1 strobe in reset", stb_a, 0);
                    check(ck_a  == 1'b0, "R1 clk in reset", ck_a, 0);
                    check(stb_b == 1'b0 && ck_b == 1'b0, "R1 ratio7 in reset", {stb_b, ck_b}, 0);
                end
                rst_cycles++;
                last_stb  = -1;
                last_edge = -1;
                prev_ck   = 1'b0;
            end else begin
                rst_cycles = 0;
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.cyc == RA)
                        check(stb_a == 1'b1, "R2 first strobe", stb_a, 1);
                    check(stb_a == e.stb, "R3 strobe value", stb_a, e.stb);
                    check(ck_a == e.ck, "R5 R6 clk value", ck_a, e.ck);
                    check(stb_b == model_stb(e.cyc, RB), "R9 ratio7 strobe", stb_b, model_stb(e.cyc, RB));
                    check(ck_b == model_ck(e.cyc, RB), "R9 ratio7 clk", ck_b, model_ck(e.cyc, RB));
                    if (stb_a) begin
                        if (last_stb >= 0)
                            check(int'(e.cyc) - last_stb == RA, "R4 strobe gap", int'(e.cyc) - last_stb, RA);
                        last_stb = e.cyc;
                    end
                    if (ck_a != prev_ck) begin
                        if (last_edge >= 0)
                            check(int'(e.cyc) - last_edge == RA, "R7 half period", int'(e.cyc) - last_edge, RA);
                        else
                            check(e.cyc == RA + 1, "R7 first rise", e.cyc, RA + 1);
                        last_edge = e.cyc;
                    end
                    prev_ck = ck_a;
                end
            end
        end
    end

    initial begin
        run_phase(450);
        run_phase(650);   // R8 restart after mid-run reset
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule